// File: doc/BRIEF.md
# SPI Flash Direct-Read Engine

This engine turns a read request that falls inside a chip-select window into a single-bit SPI flash read frame, and returns a 32-bit word. Each attached flash chip has its own 32-bit control word. That word supplies the access mode, the command opcode, the number of dummy bytes and the minimum chip-select high time. A separate vector holds one bit per chip that picks a 3-byte or 4-byte address phase.

A request carries a chip index and a byte offset inside that chip's window. The engine sends the opcode, the address and any dummy bytes on MOSI, MSB first, in SPI mode 0. It then clocks in four data bytes on MISO and packs them little-endian into the response word. SCLK is the system clock divided by two and idles low. The engine handles one frame at a time.

Back-pressure rules for the two streams:
- `req_ready` is high only when all three hold: no frame is in flight, the chip-select gap of the last frame has run out, and no response is waiting.
- A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- Once `rsp_valid` rises, it stays high with `rsp_data` unchanged until `rsp_ready` is seen high at a clock edge.

Top module: `sdr_engine`

## Requirements
- R1: After reset, every `spi_cs_n` bit is high, `spi_sclk` is low, `rsp_valid` is low and `req_ready` is high.
- R2: In mode 0 (control bits [1:0] = 0), a frame is made of three parts, in order. First the opcode from control bits [23:16], MSB first. Then the address. Then exactly 32 data clocks. No dummy clocks are sent, whatever the dummy field holds.
- R3: In mode 1 (bits [1:0] = 1), the dummy byte count is {bit 14, bits [7:6]} of the control word, so it ranges from 0 to 7. That many times 8 SCLK cycles come between the address and the data. MOSI is low during the dummy and data clocks.
- R4: Bit i of `wide_addr_en` picks the address width for chip i. When the bit is set, 32 address bits are sent: the offset, zero-extended, MSB first. When it is clear, offset bits [23:0] are sent.
- R5: Data bits are sampled on the rising SCLK edges after the dummy phase. Each byte arrives MSB first. The first byte received is placed in `rsp_data[7:0]`, and the fourth in `[31:24]`.
- R6: SCLK toggles every system clock cycle and only while a chip select is low. Only the chosen chip's `spi_cs_n` goes low. It goes low exactly one clock cycle before the first rising SCLK edge.
- R7: Control bits [27:24] hold a value v that sets the gap length G = 16 - v clock cycles. After a frame ends, all chip selects stay high for at least G cycles. When requests come back to back and a response is taken at once, the high time is exactly G for G >= 2.
- R8: A request to a chip in mode 2 or 3 starts no SPI activity: all chip selects stay high. It is answered with an all-zero word.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine can take a request |
| req_chip | input | CS_W | Index of the target chip |
| req_offset | input | ADDR_W | Byte offset inside the chip window |
| ctl_regs | input | NUM_CS*32 | Packed per-chip control words, with chip 0 in the lowest 32 bits |
| wide_addr_en | input | NUM_CS | Per-chip 4-byte address select |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Consumer takes the read word |
| rsp_data | output | 32 | Read word, little-endian byte order |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench uses a behavioral flash that records every MOSI bit on rising SCLK. The flash returns a byte pattern that depends on the address, and it starts driving data once the expected header length has passed. Four kinds of frame are tried:
- mode 0 with an empty dummy field and with a full one;
- mode 1 with a dummy count of 1 and of 5;
- both address widths, and a second chip.

These frames separate errors in the header length, in how the split dummy field is read, in address width selection and in the byte order. Back-to-back requests with gap values of 4 and 16 show whether the chip-select high time is counted from the right end. Requests in modes 2 and 3 show whether the engine stays off the bus. A response held by low `rsp_ready` shows whether the data stays stable and the request side stays blocked.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int CTL_W = 32;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_FAST  = 2'd1,
    MD_WRITE = 2'd2,
    MD_USER  = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [7:0] opcode;
    logic [2:0] dummy;      // dummy bytes actually sent
    logic       wide_addr;  // 1: 4-byte address phase
    logic [4:0] gap;        // chip-select high cycles, 1..16
  } chip_cfg_t;

  function automatic chip_cfg_t unpack_ctl(input logic [CTL_W-1:0] w, input logic wide);
    chip_cfg_t c;
    c.mode      = mode_e'(w[1:0]);
    c.opcode    = w[23:16];
    c.dummy     = (w[1:0] == 2'd1) ? {w[14], w[7:6]} : 3'd0;
    c.wide_addr = wide;
    c.gap       = 5'd16 - {1'b0, w[27:24]};
    return c;
  endfunction
endpackage

// File: rtl/sdr_cfg_select.sv
module sdr_cfg_select
  import sdr_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*CTL_W-1:0] ctl_regs,
  input  logic [NUM_CS-1:0]       wide_en,
  input  logic [CS_W-1:0]         sel,
  output chip_cfg_t               cfg
);
  chip_cfg_t per_chip [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_chip
    assign per_chip[i] = unpack_ctl(ctl_regs[i*CTL_W +: CTL_W], wide_en[i]);
  end

  always_comb begin
    cfg = per_chip[0];
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == CS_W'(i)) cfg = per_chip[i];
    end
  end
endmodule

// File: rtl/sdr_bit_engine.sv
module sdr_bit_engine #(
  parameter int HDR_W     = 40,
  parameter int DATA_BITS = 32,
  localparam int CNT_W    = 8,
  localparam int LEN_W    = $clog2(HDR_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [HDR_W-1:0]     hdr_in,
  input  logic [LEN_W-1:0]     hdr_bits,
  input  logic [5:0]           dummy_bits,
  input  logic                 miso,
  output logic                 active,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 fin,
  output logic [DATA_BITS-1:0] rx_word
);
  logic [HDR_W-1:0] tx;
  logic [CNT_W-1:0] cnt, total, sample_from;

  assign fin  = active && sclk && (cnt == total - 1'b1);
  assign mosi = active & tx[HDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      sclk        <= 1'b0;
      tx          <= '0;
      cnt         <= '0;
      total       <= '0;
      sample_from <= '0;
      rx_word     <= '0;
    end else if (start) begin
      active      <= 1'b1;
      sclk        <= 1'b0;
      cnt         <= '0;
      tx          <= hdr_in;
      total       <= CNT_W'(hdr_bits) + CNT_W'(dummy_bits) + CNT_W'(DATA_BITS);
      sample_from <= CNT_W'(hdr_bits) + CNT_W'(dummy_bits);
    end else if (active) begin
      if (!sclk) begin
        // rising edge: capture a data bit once header and dummies are out
        sclk <= 1'b1;
        if (cnt >= sample_from) rx_word <= {rx_word[DATA_BITS-2:0], miso};
      end else begin
        // falling edge: present the next outgoing bit
        sclk <= 1'b0;
        tx   <= {tx[HDR_W-2:0], 1'b0};
        cnt  <= cnt + 1'b1;
        if (fin) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int GAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] len,
  output logic             busy
);
  logic [GAP_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= len - 1'b1;
    else if (busy)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sdr_engine.sv
module sdr_engine
  import sdr_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 26,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CS_W-1:0]         req_chip,
  input  logic [ADDR_W-1:0]       req_offset,
  input  logic [NUM_CS*CTL_W-1:0] ctl_regs,
  input  logic [NUM_CS-1:0]       wide_addr_en,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_data,
  output logic                    spi_sclk,
  output logic [NUM_CS-1:0]       spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int HDR_W = 40;

  chip_cfg_t        cfg;
  logic             accept, direct, start;
  logic [31:0]      addr32;
  logic [HDR_W-1:0] hdr;
  logic [5:0]       hdr_bits;
  logic             eng_active, eng_fin, gap_busy;
  logic [31:0]      rx_word;
  logic [CS_W-1:0]  chip_q;
  logic [4:0]       gap_q;

  sdr_cfg_select #(.NUM_CS(NUM_CS)) u_sel (
    .ctl_regs (ctl_regs),
    .wide_en  (wide_addr_en),
    .sel      (req_chip),
    .cfg      (cfg)
  );

  assign req_ready = !eng_active && !gap_busy && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign direct    = (cfg.mode == MD_READ) || (cfg.mode == MD_FAST);
  assign start     = accept && direct;

  assign addr32   = 32'(req_offset);
  assign hdr      = cfg.wide_addr ? {cfg.opcode, addr32} : {cfg.opcode, addr32[23:0], 8'h00};
  assign hdr_bits = cfg.wide_addr ? 6'd40 : 6'd32;

  sdr_bit_engine #(.HDR_W(HDR_W), .DATA_BITS(32)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .hdr_in     (hdr),
    .hdr_bits   (hdr_bits),
    .dummy_bits ({cfg.dummy, 3'b000}),
    .miso       (spi_miso),
    .active     (eng_active),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .fin        (eng_fin),
    .rx_word    (rx_word)
  );

  sdr_gap_timer #(.GAP_W(5)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (eng_fin),
    .len   (gap_q),
    .busy  (gap_busy)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !(eng_active && (chip_q == CS_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      chip_q    <= '0;
      gap_q     <= 5'd16;
    end else begin
      if (start) begin
        chip_q <= req_chip;
        gap_q  <= cfg.gap;
      end
      if (eng_fin) begin
        rsp_valid <= 1'b1;
        rsp_data  <= {rx_word[7:0], rx_word[15:8], rx_word[23:16], rx_word[31:24]};
      end else if (accept && !direct) begin
        rsp_valid <= 1'b1;
        rsp_data  <= '0;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdr_engine_checker.sv
module sdr_engine_checker #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic              spi_sclk,
  input logic [NUM_CS-1:0] spi_cs_n
);
  assert_sclk_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !(&spi_cs_n));

  assert_single_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  assert_cs_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&spi_cs_n) |-> !spi_sclk);

  assert_gap_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&spi_cs_n) |-> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_pending_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind sdr_engine sdr_engine_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/sdr_engine_bench.sv
`timescale 1ns/1ps
module sdr_engine_bench;
  localparam int NUM_CS = 2;
  localparam int ADDR_W = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [0:0] req_chip = '0;
  logic [ADDR_W-1:0] req_offset = '0;
  logic [63:0] ctl_regs = '0;
  logic [1:0] wide_addr_en = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;
  logic [1:0] spi_cs_n;

  always #2.5 clk = ~clk;

  sdr_engine #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_sdr_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chip(req_chip), .req_offset(req_offset), .ctl_regs(ctl_regs),
    .wide_addr_en(wide_addr_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioral flash ----------------
  int bitn = 0;
  int mdl_skip = 32;
  logic [31:0] mdl_addr = '0;
  logic [127:0] cap = '0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h91;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
  endfunction

  always @(posedge spi_sclk) begin
    if (bitn < 128) cap[bitn] = spi_mosi;
    bitn = bitn + 1;
  end

  always @(negedge spi_sclk) begin
    if (bitn >= mdl_skip) begin
      int d;
      logic [7:0] b;
      d = bitn - mdl_skip;
      b = pat(mdl_addr + 32'(d / 8));
      spi_miso <= b[7 - (d % 8)];
    end
  end

  // ---------------- bus monitor ----------------
  int hi_cnt = 0, last_hi = 0, low_cnt = 0, lead_rec = -1, cs_falls = 0;
  bit seen_clk = 0, prev_hi = 1;
  logic [1:0] low_seen = '0;

  always @(negedge clk) begin
    low_seen = low_seen | ~spi_cs_n;
    if (&spi_cs_n) begin
      hi_cnt++;
      low_cnt = 0;
      seen_clk = 0;
      prev_hi = 1;
    end else begin
      if (prev_hi) begin
        last_hi = hi_cnt;
        cs_falls++;
      end
      prev_hi = 0;
      hi_cnt = 0;
      if (spi_sclk && !seen_clk) begin
        lead_rec = low_cnt;
        seen_clk = 1;
      end
      low_cnt++;
    end
  end

  function automatic logic [39:0] cap_field(input int from, input int n);
    logic [39:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[38:0], cap[from + i]};
    return v;
  endfunction

  function automatic logic [31:0] mk_ctl(input int mode, input logic [7:0] op, input logic [2:0] dum, input logic [3:0] inact);
    logic [31:0] w = '0;
    w[1:0]   = mode[1:0];
    w[23:16] = op;
    w[14]    = dum[2];
    w[7:6]   = dum[1:0];
    w[27:24] = inact;
    return w;
  endfunction

  logic [31:0] got_word;
  int got_bits;

  task automatic do_read(input int chip, input logic [31:0] off, input int skip);
    int guard;
    guard = 0;
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    mdl_addr = off; mdl_skip = skip; bitn = 0; cap = '0; low_seen = '0; lead_rec = -1;
    req_chip = chip[0:0]; req_offset = off[ADDR_W-1:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
    got_word = rsp_data;
    got_bits = bitn;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1", "cs_n idle", {38'd0, spi_cs_n}, 40'h3);
    chk("R1", "sclk idle", {39'd0, spi_sclk}, 40'h0);
    chk("R1", "rsp_valid", {39'd0, rsp_valid}, 40'h0);
    chk("R1", "req_ready", {39'd0, req_ready}, 40'h1);
  endtask

  task automatic t_normal_3byte;
    ctl_regs[31:0] = mk_ctl(0, 8'h03, 3'd0, 4'd15);
    wide_addr_en = 2'b00;
    do_read(0, 32'h0012_3456, 32);
    chk("R2", "opcode", cap_field(0, 8), 40'h03);
    chk("R4", "3-byte address", cap_field(8, 24), 40'h12_3456);
    chk("R2", "clock count", 40'(got_bits), 40'd64);
    chk("R5", "data word", {8'd0, got_word}, {8'd0, exp_word(32'h0012_3456)});
    chk("R6", "cs lead cycles", 40'(lead_rec), 40'd1);
    chk("R6", "other cs idle", {38'd0, low_seen}, 40'h1);
  endtask

  task automatic t_normal_ignores_dummy;
    ctl_regs[31:0] = mk_ctl(0, 8'h13, 3'd7, 4'd15);
    do_read(0, 32'h0000_00F0, 32);
    chk("R2", "no dummy in mode 0", 40'(got_bits), 40'd64);
    chk("R2", "data with dummy field set", {8'd0, got_word}, {8'd0, exp_word(32'h0000_00F0)});
  endtask

  task automatic t_fast_wide;
    ctl_regs[31:0] = mk_ctl(1, 8'h0B, 3'd1, 4'd15);
    wide_addr_en = 2'b01;
    do_read(0, 32'h02AB_CDEF, 48);
    chk("R2", "fast opcode", cap_field(0, 8), 40'h0B);
    chk("R4", "4-byte address", cap_field(8, 32), 40'h02AB_CDEF);
    chk("R3", "dummy=1 clock count", 40'(got_bits), 40'd80);
    chk("R3", "dummy bits low", cap_field(40, 8), 40'h0);
    chk("R5", "fast data", {8'd0, got_word}, {8'd0, exp_word(32'h02AB_CDEF)});
  endtask

  task automatic t_fast_split_field;
    ctl_regs[31:0] = mk_ctl(1, 8'h0B, 3'd5, 4'd15);
    wide_addr_en = 2'b00;
    do_read(0, 32'h0000_1001, 72);
    chk("R3", "dummy=5 clock count", 40'(got_bits), 40'd104);
    chk("R3", "dummy bits low", cap_field(32, 40), 40'h0);
    chk("R5", "data after 5 dummies", {8'd0, got_word}, {8'd0, exp_word(32'h0000_1001)});
  endtask

  task automatic t_second_chip;
    ctl_regs[63:32] = mk_ctl(0, 8'h03, 3'd0, 4'd15);
    wide_addr_en = 2'b10;
    do_read(1, 32'h0300_0010, 40);
    chk("R6", "only chip1 selected", {38'd0, low_seen}, 40'h2);
    chk("R4", "chip1 wide address", cap_field(8, 32), 40'h0300_0010);
    chk("R5", "chip1 data", {8'd0, got_word}, {8'd0, exp_word(32'h0300_0010)});
  endtask

  task automatic t_gap(input logic [3:0] inact, input int g);
    ctl_regs[31:0] = mk_ctl(0, 8'h03, 3'd0, inact);
    wide_addr_en = 2'b00;
    do_read(0, 32'h0000_0100, 32);
    do_read(0, 32'h0000_0200, 32);
    chk("R7", $sformatf("cs high gap field %0d", inact), 40'(last_hi), 40'(g));
    chk("R7", "data after gap", {8'd0, got_word}, {8'd0, exp_word(32'h0000_0200)});
  endtask

  task automatic t_no_direct(input int mode);
    int falls0;
    ctl_regs[31:0] = mk_ctl(mode, 8'h03, 3'd0, 4'd15);
    falls0 = cs_falls;
    do_read(0, 32'h0000_0040, 32);
    repeat (3) @(negedge clk);
    chk("R8", $sformatf("no cs activity mode %0d", mode), 40'(cs_falls - falls0), 40'd0);
    chk("R8", $sformatf("zero word mode %0d", mode), {8'd0, got_word}, 40'h0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    ctl_regs[31:0] = mk_ctl(0, 8'h03, 3'd0, 4'd15);
    rsp_ready = 1'b0;
    do_read(0, 32'h0000_0777, 32);
    held = rsp_data;
    repeat (6) @(negedge clk);
    chk("R9", "valid held", {39'd0, rsp_valid}, 40'h1);
    chk("R9", "data held", {8'd0, rsp_data}, {8'd0, held});
    chk("R9", "request blocked", {39'd0, req_ready}, 40'h0);
    chk("R5", "held data value", {8'd0, held}, {8'd0, exp_word(32'h0000_0777)});
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9", "valid drops after take", {39'd0, rsp_valid}, 40'h0);
  endtask

  initial begin
    ctl_regs[31:0]  = mk_ctl(0, 8'h03, 3'd0, 4'd15);
    ctl_regs[63:32] = mk_ctl(0, 8'h03, 3'd0, 4'd15);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_3byte();
    t_normal_ignores_dummy();
    t_fast_wide();
    t_fast_split_field();
    t_second_chip();
    t_gap(4'd12, 4);
    t_gap(4'd0, 16);
    t_no_direct(2);
    t_no_direct(3);
    t_backpressure();
    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #400us;
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired, all requirements R1 through R9 unfinished: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule